// File: doc/BRIEF.md
# Zero-Overhead Loop Program Sequencer

This block chooses the next instruction fetch address for a small processor core. Each cycle it takes the already decoded kind of the instruction at the current fetch address, together with a branch target, a condition result and, for loop set-up instructions, a loop end address and an iteration count. Jumps, calls and returns resolve in a single cycle. Calls save their return address on a hardware return-address stack.

Hardware loops are kept on a loop stack that records the start address, end address and remaining count of each active loop. When the fetch address reaches the end address of the innermost loop, the sequencer goes back to the loop start on its own. No branch instruction and no extra cycle is needed. Loops nest up to the depth of the loop stack. A stall input freezes the address and all stacks. Pushing onto a full stack is recorded in a sticky overflow flag.

Top module: `zol_sequencer`

## Requirements
- R1: While reset is asserted, and on its release, the fetch address equals the reset address (0 by default) and both overflow flags are 0.
- R2: An instruction with code 0 (sequential), or with an unused code 5, 6 or 7, moves the fetch address to the current address plus 1, wrapping modulo 2^14. This applies when the current address is not the end of the innermost loop.
- R3: Code 1 (jump) moves to the target address in the next cycle when the condition is true, and to the current address plus 1 when it is false.
- R4: Code 2 (call) with a true condition moves to the target and saves the current address plus 1 on the return stack. With a false condition it moves to the current address plus 1 and saves nothing.
- R5: Code 3 (return) with a true condition and a non-empty return stack removes the newest saved address and fetches from it. With a false condition, or with an empty return stack, it moves to the current address plus 1.
- R6: Code 4 (loop set-up) records a loop whose start is the current address plus 1, with the given end address and count, and moves to the current address plus 1.
- R7: When the fetch address equals the innermost loop's end address and its remaining count is above 1, the next address is that loop's start and the count drops by 1. This adds no cycle.
- R8: When the fetch address equals the innermost loop's end address and its remaining count is 1 or less, that loop is discarded and the fetch address moves to the end address plus 1.
- R9: Loops nest. When an inner loop finishes, the enclosing loop's end address and count take effect again.
- R10: A taken jump, call or return, or a loop set-up instruction, at the innermost loop's end address takes priority, and that loop is not checked in that cycle. An untaken branch at the end address does let the loop check act.
- R11: While stall is 1, the fetch address, the return stack and the loop stacks keep their values whatever the instruction inputs are.
- R12: A call taken while the return stack is full discards the new entry and sets pc_ovf. pc_ovf then stays 1 until reset.
- R13: A loop set-up while the loop stack is full discards the new loop and sets loop_ovf. loop_ovf then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freeze sequencer state this cycle |
| op | input | 3 | Decoded instruction kind (0 seq, 1 jump, 2 call, 3 return, 4 loop set-up) |
| target | input | AW (14) | Jump or call destination |
| cond_true | input | 1 | Branch condition result |
| loop_end | input | AW (14) | Last address of the loop being set up |
| loop_count | input | CW (14) | Iteration count of the loop being set up |
| fetch_addr | output | AW (14) | Current instruction fetch address |
| pc_ovf | output | 1 | Sticky return-stack overflow |
| loop_ovf | output | 1 | Sticky loop-stack overflow |

## Verification
The bench builds the sequencer with a return stack 4 deep and a loop stack 2 deep, and keeps 14-bit addresses and counts. The shallow stacks let a short run of calls and loop set-ups reach the full condition. This brings overflow, entry discard and the sticky flags within reach. It also exercises nesting of two loops, including an inner loop of one instruction whose start equals its end. The 14-bit width is kept so that address wrap from 0x3FFF to 0 is covered.

// File: rtl/zol_pkg.sv
package zol_pkg;

  typedef enum logic [2:0] {
    OP_SEQ  = 3'd0,
    OP_JUMP = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_LOOP = 3'd4
  } zol_op_e;

endpackage

// File: rtl/zol_stack.sv
module zol_stack #(
  parameter int W     = 14,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         wr_top,
  input  logic [W-1:0] push_data,
  input  logic [W-1:0] top_wdata,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full,
  output logic         ovf
);

  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            ovf_q, ovf_d;
  logic [W-1:0]    mem [DEPTH];
  logic [IW-1:0]   wr_idx, top_idx;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNTW'(DEPTH));
  assign wr_idx  = IW'(cnt_q);
  assign top_idx = IW'(cnt_q - CNTW'(1));
  assign top     = empty ? '0 : mem[top_idx];
  assign ovf     = ovf_q;

  // occupancy and sticky overflow next state
  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (push) begin
      if (full) ovf_d = 1'b1;
      else      cnt_d = cnt_q + CNTW'(1);
    end else if (pop && !empty) begin
      cnt_d = cnt_q - CNTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  // storage: no reset, written only on an accepted push or a top update
  always_ff @(posedge clk) begin
    if (push && !full)
      mem[wr_idx] <= push_data;
    else if (wr_top && !empty && !pop)
      mem[top_idx] <= top_wdata;
  end

  // R12 R13
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full) |=> (cnt_q == $past(cnt_q) + CNTW'(1)));

  // R12 R13
  push_full_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (ovf && cnt_q == CNTW'(DEPTH)));

  // R12 R13
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R5 R8
  pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !empty) |=> (cnt_q == $past(cnt_q) - CNTW'(1)));

endmodule

// File: rtl/zol_next_pc.sv
module zol_next_pc
  import zol_pkg::*;
#(
  parameter int AW = 14,
  parameter int CW = 14
) (
  input  logic [AW-1:0] pc,
  input  logic          stall,
  input  logic [2:0]    op,
  input  logic [AW-1:0] target,
  input  logic          cond_true,
  input  logic [AW-1:0] ret_top,
  input  logic          ret_empty,
  input  logic          lp_active,
  input  logic [AW-1:0] lp_start,
  input  logic [AW-1:0] lp_end,
  input  logic [CW-1:0] lp_count,
  output logic [AW-1:0] npc,
  output logic          ret_push,
  output logic          ret_pop,
  output logic          lp_push,
  output logic          lp_pop,
  output logic          lp_dec
);

  logic [AW-1:0] seq_pc;
  logic          skip_loop_chk;
  logic          at_loop_end;

  assign seq_pc      = pc + AW'(1);
  assign at_loop_end = lp_active && (pc == lp_end);

  always_comb begin
    npc           = seq_pc;
    ret_push      = 1'b0;
    ret_pop       = 1'b0;
    lp_push       = 1'b0;
    lp_pop        = 1'b0;
    lp_dec        = 1'b0;
    skip_loop_chk = 1'b0;

    case (op)
      OP_JUMP: begin
        if (cond_true) begin
          npc           = target;
          skip_loop_chk = 1'b1;
        end
      end
      OP_CALL: begin
        if (cond_true) begin
          npc           = target;
          ret_push      = 1'b1;
          skip_loop_chk = 1'b1;
        end
      end
      OP_RET: begin
        if (cond_true && !ret_empty) begin
          npc           = ret_top;
          ret_pop       = 1'b1;
          skip_loop_chk = 1'b1;
        end
      end
      OP_LOOP: begin
        lp_push       = 1'b1;
        skip_loop_chk = 1'b1;
      end
      default: ;
    endcase

    if (!skip_loop_chk && at_loop_end) begin
      if (lp_count > CW'(1)) begin
        npc    = lp_start;
        lp_dec = 1'b1;
      end else begin
        lp_pop = 1'b1;
      end
    end

    if (stall) begin
      npc      = pc;
      ret_push = 1'b0;
      ret_pop  = 1'b0;
      lp_push  = 1'b0;
      lp_pop   = 1'b0;
      lp_dec   = 1'b0;
    end
  end

endmodule

// File: rtl/zol_sequencer.sv
module zol_sequencer
  import zol_pkg::*;
#(
  parameter int            AW         = 14,
  parameter int            CW         = 14,
  parameter int            PC_DEPTH   = 16,
  parameter int            LOOP_DEPTH = 4,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic [2:0]    op,
  input  logic [AW-1:0] target,
  input  logic          cond_true,
  input  logic [AW-1:0] loop_end,
  input  logic [CW-1:0] loop_count,
  output logic [AW-1:0] fetch_addr,
  output logic          pc_ovf,
  output logic          loop_ovf
);

  localparam int LAW = 2 * AW;

  logic [AW-1:0]  pc_q, pc_d, npc;
  logic           pc_en;
  logic           ret_push, ret_pop, lp_push, lp_pop, lp_dec;
  logic [AW-1:0]  ret_top;
  logic           ret_empty, ret_full;
  logic [LAW-1:0] la_top, la_push_data;
  logic           la_empty, la_full, la_ovf;
  logic [CW-1:0]  lc_top, lc_dec_val;
  logic           lc_empty, lc_full, lc_ovf;
  logic [AW-1:0]  lp_start_top, lp_end_top;
  logic [AW-1:0]  ret_push_data;

  assign ret_push_data = pc_q + AW'(1);
  assign la_push_data  = {pc_q + AW'(1), loop_end};
  assign lp_start_top  = la_top[LAW-1:AW];
  assign lp_end_top    = la_top[AW-1:0];
  assign lc_dec_val    = lc_top - CW'(1);

  zol_next_pc #(.AW(AW), .CW(CW)) u_next (
    .pc        (pc_q),
    .stall     (stall),
    .op        (op),
    .target    (target),
    .cond_true (cond_true),
    .ret_top   (ret_top),
    .ret_empty (ret_empty),
    .lp_active (!la_empty),
    .lp_start  (lp_start_top),
    .lp_end    (lp_end_top),
    .lp_count  (lc_top),
    .npc       (npc),
    .ret_push  (ret_push),
    .ret_pop   (ret_pop),
    .lp_push   (lp_push),
    .lp_pop    (lp_pop),
    .lp_dec    (lp_dec)
  );

  zol_stack #(.W(AW), .DEPTH(PC_DEPTH)) u_ret_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ret_push),
    .pop       (ret_pop),
    .wr_top    (1'b0),
    .push_data (ret_push_data),
    .top_wdata ('0),
    .top       (ret_top),
    .empty     (ret_empty),
    .full      (ret_full),
    .ovf       (pc_ovf)
  );

  zol_stack #(.W(LAW), .DEPTH(LOOP_DEPTH)) u_loop_addr_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (lp_push),
    .pop       (lp_pop),
    .wr_top    (1'b0),
    .push_data (la_push_data),
    .top_wdata ('0),
    .top       (la_top),
    .empty     (la_empty),
    .full      (la_full),
    .ovf       (la_ovf)
  );

  zol_stack #(.W(CW), .DEPTH(LOOP_DEPTH)) u_loop_cnt_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (lp_push),
    .pop       (lp_pop),
    .wr_top    (lp_dec),
    .push_data (loop_count),
    .top_wdata (lc_dec_val),
    .top       (lc_top),
    .empty     (lc_empty),
    .full      (lc_full),
    .ovf       (lc_ovf)
  );

  assign loop_ovf = la_ovf | lc_ovf;

  // program counter: next state and register with explicit enable
  assign pc_en = !stall;
  assign pc_d  = npc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= RESET_ADDR;
    else if (pc_en) pc_q <= pc_d;
  end

  assign fetch_addr = pc_q;

  // R3
  jmp_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && op == OP_JUMP && cond_true) |=> (fetch_addr == $past(target)));

  // R4
  call_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && op == OP_CALL && cond_true && !ret_full)
      |=> (fetch_addr == $past(target) && ret_top == $past(fetch_addr) + AW'(1)));

  // R7
  loop_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && op == OP_SEQ && !la_empty && fetch_addr == lp_end_top && lc_top > CW'(1))
      |=> (fetch_addr == $past(lp_start_top) && lc_top == $past(lc_top) - CW'(1)));

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(fetch_addr) && $stable(ret_top) && $stable(la_top) && $stable(lc_top)));

  // R9
  loop_stacks_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (la_empty == lc_empty) && (la_full == lc_full));

endmodule

// File: tb/sim_zol_sequencer.sv
module sim_zol_sequencer;

  localparam int AW = 14;
  localparam int CW = 14;

  logic          clk;
  logic          rst_n;
  logic          stall;
  logic [2:0]    op;
  logic [AW-1:0] target;
  logic          cond_true;
  logic [AW-1:0] loop_end;
  logic [CW-1:0] loop_count;
  logic [AW-1:0] fetch_addr;
  logic          pc_ovf;
  logic          loop_ovf;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  localparam logic [2:0] C_SEQ = 3'd0, C_JMP = 3'd1, C_CALL = 3'd2,
                         C_RET = 3'd3, C_LOOP = 3'd4;

  zol_sequencer #(.AW(AW), .CW(CW), .PC_DEPTH(4), .LOOP_DEPTH(2)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .op         (op),
    .target     (target),
    .cond_true  (cond_true),
    .loop_end   (loop_end),
    .loop_count (loop_count),
    .fetch_addr (fetch_addr),
    .pc_ovf     (pc_ovf),
    .loop_ovf   (loop_ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<=20000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one instruction: drive on the falling edge, observe just after the rising edge
  task automatic step(input logic [2:0] o, input logic [AW-1:0] t, input logic c,
                      input logic [AW-1:0] le, input logic [CW-1:0] lc, input logic s);
    @(negedge clk);
    op = o; target = t; cond_true = c; loop_end = le; loop_count = lc; stall = s;
    @(posedge clk);
    #1;
  endtask

  task automatic seq_step();
    step(C_SEQ, '0, 1'b0, '0, '0, 1'b0);
  endtask

  task automatic go(input logic [AW-1:0] a);
    step(C_JMP, a, 1'b1, '0, '0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; stall = 1'b0; op = C_SEQ; target = '0; cond_true = 1'b0;
    loop_end = '0; loop_count = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset addr", fetch_addr, 0);
    chk("R1 pc_ovf", pc_ovf, 0);
    chk("R1 loop_ovf", loop_ovf, 0);
    @(negedge clk);
    stall = 1'b1;
    rst_n = 1'b1;
    #1;
    chk("R1 release addr", fetch_addr, 0);
  endtask

  task automatic t_seq();
    go(14'h010);
    chk("R3 jump taken", fetch_addr, 'h010);
    seq_step();
    chk("R2 sequential", fetch_addr, 'h011);
    step(3'd6, 14'h222, 1'b1, '0, '0, 1'b0);
    chk("R2 unused code", fetch_addr, 'h012);
    go(14'h3FFF);
    seq_step();
    chk("R2 wrap", fetch_addr, 'h000);
  endtask

  task automatic t_jump();
    go(14'h100);
    step(C_JMP, 14'h555, 1'b0, '0, '0, 1'b0);
    chk("R3 jump untaken", fetch_addr, 'h101);
  endtask

  task automatic t_call();
    go(14'h120);
    step(C_CALL, 14'h200, 1'b1, '0, '0, 1'b0);
    chk("R4 call taken", fetch_addr, 'h200);
    seq_step();
    step(C_CALL, 14'h250, 1'b0, '0, '0, 1'b0);
    chk("R4 call untaken", fetch_addr, 'h202);
    step(C_RET, '0, 1'b0, '0, '0, 1'b0);
    chk("R5 return untaken", fetch_addr, 'h203);
    step(C_RET, '0, 1'b1, '0, '0, 1'b0);
    chk("R5 return taken", fetch_addr, 'h121);
    step(C_RET, '0, 1'b1, '0, '0, 1'b0);
    chk("R5 return on empty", fetch_addr, 'h122);
  endtask

  task automatic t_loop();
    int exp_seq [7] = '{'h302, 'h301, 'h302, 'h301, 'h302, 'h303, 'h304};
    go(14'h300);
    step(C_LOOP, '0, 1'b0, 14'h302, 14'd3, 1'b0);
    chk("R6 loop setup", fetch_addr, 'h301);
    for (int i = 0; i < 7; i++) begin
      seq_step();
      chk((i < 5) ? "R7 loop body" : "R8 loop exit", fetch_addr, exp_seq[i]);
    end
  endtask

  task automatic t_nest();
    int exp_seq [10] = '{'h402, 'h403, 'h404, 'h401, 'h402, 'h402, 'h403, 'h404, 'h405, 'h406};
    go(14'h400);
    step(C_LOOP, '0, 1'b0, 14'h404, 14'd2, 1'b0);
    chk("R6 outer setup", fetch_addr, 'h401);
    step(C_LOOP, '0, 1'b0, 14'h402, 14'd2, 1'b0);
    chk("R6 inner setup", fetch_addr, 'h402);
    for (int i = 0; i < 10; i++) begin
      if (i == 4) step(C_LOOP, '0, 1'b0, 14'h402, 14'd2, 1'b0);
      else        seq_step();
      chk("R9 nested loops", fetch_addr, exp_seq[i]);
    end
  endtask

  task automatic t_stall();
    go(14'h700);
    for (int i = 0; i < 3; i++) begin
      step(C_JMP, 14'h777, 1'b1, '0, '0, 1'b1);
      chk("R11 stall holds addr", fetch_addr, 'h700);
    end
    step(C_LOOP, '0, 1'b0, 14'h701, 14'd2, 1'b1);
    chk("R11 stalled loop setup", fetch_addr, 'h700);
    seq_step();
    seq_step();
    chk("R11 no loop recorded", fetch_addr, 'h702);
    step(C_CALL, 14'h7F0, 1'b1, '0, '0, 1'b1);
    chk("R11 stalled call", fetch_addr, 'h702);
    step(C_RET, '0, 1'b1, '0, '0, 1'b0);
    chk("R11 no return saved", fetch_addr, 'h703);
  endtask

  task automatic t_prio();
    go(14'h500);
    step(C_LOOP, '0, 1'b0, 14'h502, 14'd5, 1'b0);
    seq_step();
    chk("R6 prio setup", fetch_addr, 'h502);
    step(C_JMP, 14'h600, 1'b1, '0, '0, 1'b0);
    chk("R10 taken jump wins", fetch_addr, 'h600);
    go(14'h502);
    step(C_JMP, 14'h123, 1'b0, '0, '0, 1'b0);
    chk("R10 untaken jump loops", fetch_addr, 'h501);
  endtask

  task automatic t_loop_ovf();
    go(14'h800);
    step(C_LOOP, '0, 1'b0, 14'h900, 14'd2, 1'b0);
    chk("R13 fill addr", fetch_addr, 'h801);
    chk("R13 no ovf when filling", loop_ovf, 0);
    step(C_LOOP, '0, 1'b0, 14'h910, 14'd2, 1'b0);
    chk("R13 ovf set", loop_ovf, 1);
    chk("R13 pc_ovf untouched", pc_ovf, 0);
    seq_step();
    chk("R13 ovf sticky", loop_ovf, 1);
    chk("R13 addr after ovf", fetch_addr, 'h803);
  endtask

  task automatic t_pc_ovf();
    logic [AW-1:0] tg [5] = '{14'hB00, 14'hB10, 14'hB20, 14'hB30, 14'hB40};
    go(14'hA00);
    for (int i = 0; i < 4; i++) step(C_CALL, tg[i], 1'b1, '0, '0, 1'b0);
    chk("R12 no ovf at full", pc_ovf, 0);
    step(C_CALL, tg[4], 1'b1, '0, '0, 1'b0);
    chk("R12 ovf set", pc_ovf, 1);
    chk("R12 call still jumps", fetch_addr, 'hB40);
    step(C_RET, '0, 1'b1, '0, '0, 1'b0);
    chk("R12 dropped entry", fetch_addr, 'hB21);
    chk("R12 ovf sticky", pc_ovf, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    do_reset();
    t_seq();
    t_jump();
    t_call();
    t_loop();
    t_nest();
    t_stall();
    t_prio();
    t_loop_ovf();
    t_pc_ovf();
    do_reset();
    chk("R12 cleared by reset", pc_ovf, 0);
    chk("R13 cleared by reset", loop_ovf, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule